// File: doc/BRIEF.md
# Video DRAM Access Cycle Decoder

This block sits on the controller side of a dual-port video memory, which has a random-access array port and a serial shift port. It watches the row strobe, the two byte column strobes, the transfer strobe, the write strobe and the special-function pin, all sampled on the system clock. When the row strobe rises it reports what kind of access the cycle just ended was. The possible kinds are:

- a read or a write, plain or masked;
- a block write;
- a mask-register load or a color-register load;
- one of several register transfers;
- one of three refresh variants;
- an illegal combination.

With the report it gives the row address, the column and block addresses, the write data and the masks that apply. It also keeps the state that the memory keeps across cycles: the write-mask register, the color register, the stop-point code and enable, and the persistent per-bit masking flag. The refresh variant that resets modes is the only thing that clears the flag and the stop-point enable. The downstream array and serial models use these reports to act on each cycle.

Top module: `vram_cycle_decoder`

## Requirements
- R1: After reset `cyc_valid` is 0, `persist_on` and `stop_on` are 0, `mask_reg` is all ones, `color_reg` and `stop_code` are 0.
- R2: Each row-strobe rise that ends a cycle gives exactly one `cyc_valid` pulse, one clock long, visible in the clock after the rise is sampled. `cyc_code` is then set as follows.
  - Column strobe low at the row fall (refresh): write low with special low gives 15 (illegal). Write low with special high gives 14 (stop-point set). Write high with special low gives 13 (refresh that clears modes). Write high with special high gives 12 (refresh that keeps modes).
  - Transfer low at the row fall: write high gives 7 with special low, or 8 with special high. Write low with special low gives 9. Write low with special high gives 10 if special is low at the first column fall, or 11 if it is high.
  - Transfer high with write low: special high gives 15. Special low gives 2 (masked write), or 4 (masked block write) if special is high at the column fall.
  - Transfer high with write high and special high: 5 (mask load) if special is low at the column fall, or 6 (color load) if it is high.
  - Transfer high with write high and special low: 0 (read) if no write fall follows. If a write fall follows, 1 (write), or 3 (block write) if special is high at the column fall.
- R3: The combined column strobe is low when either byte strobe is low. `col_addr` holds the address present at the first combined column fall after the row fall, and `blk_addr` holds bits 8..3 of that address.
- R4: `wr_data` is the data bus at the later of the first column fall and the write fall. If write is already low at the column fall, it is the bus at the column fall.
- R5: For codes 3 and 4 `col_mask` equals the captured data. For every other code it is all ones.
- R6: Code 5 loads the captured data into `mask_reg` and sets `persist_on`. Code 6 loads the captured data into `color_reg`.
- R7: Code 13 clears `persist_on` and `stop_on`. Code 12 leaves both unchanged.
- R8: Code 14 sets `stop_on` and loads `stop_code` from row address bits 7..4. Address bits 3..0 and bit 8 are ignored.
- R9: For codes 2, 4, 9, 10 and 11 `wr_mask` is `mask_reg` when `persist_on` is set, and otherwise the data bus sampled at the row fall. For all other codes it is all ones.
- R10: Code 15 changes none of `mask_reg`, `color_reg`, `stop_code`, `stop_on` or `persist_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Lower-byte column strobe, active low |
| casu_n | input | 1 | Upper-byte column strobe, active low |
| trg_n | input | 1 | Transfer / output-enable strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| dsf | input | 1 | Special-function select |
| addr | input | 9 | Multiplexed address |
| dq | input | 16 | Data bus |
| cyc_valid | output | 1 | One-clock report pulse |
| cyc_code | output | 4 | Cycle code |
| row_addr | output | 9 | Row address of the cycle |
| col_addr | output | 9 | Column address |
| blk_addr | output | 6 | Block address (column bits 8..3) |
| wr_data | output | 16 | Captured write data |
| wr_mask | output | 16 | Effective per-bit write mask |
| col_mask | output | 16 | Block-write column mask |
| persist_on | output | 1 | Persistent per-bit mask mode |
| stop_on | output | 1 | Stop-point mode |
| stop_code | output | 4 | Stop-point code |
| mask_reg | output | 16 | Stored write mask |
| color_reg | output | 16 | Stored color |

## Verification
The assertions assume that the strobes are already synchronous to the clock. They also assume that every row-strobe low phase lasts at least one clock, so a report pulse can never be followed directly by another. The stimulus moves each strobe on a falling clock edge and holds it for whole clocks. It never lets the write fall and the row rise in the same clock, so each captured value is settled before the report.

// File: rtl/vram_dec_pkg.sv
package vram_dec_pkg;

  typedef enum logic [3:0] {
    CY_READ       = 4'd0,
    CY_WRITE      = 4'd1,
    CY_WRITE_M    = 4'd2,
    CY_BLOCK      = 4'd3,
    CY_BLOCK_M    = 4'd4,
    CY_LOAD_MASK  = 4'd5,
    CY_LOAD_COLOR = 4'd6,
    CY_XF_RD      = 4'd7,
    CY_XF_SPLIT   = 4'd8,
    CY_XF_WM      = 4'd9,
    CY_XF_SPLIT_W = 4'd10,
    CY_XF_FLASH   = 4'd11,
    CY_REF_KEEP   = 4'd12,
    CY_REF_CLEAR  = 4'd13,
    CY_REF_STOP   = 4'd14,
    CY_ILLEGAL    = 4'd15
  } cyc_e;

  // Final classification from the levels stored at the row fall, the
  // special pin at the first column fall and whether write fell later.
  function automatic cyc_e classify(input logic cbr, input logic trg_n,
                                    input logic we_n, input logic dsf,
                                    input logic dsf_cas, input logic we_fell);
    cyc_e c;
    if (cbr) begin
      if (!we_n) c = dsf ? CY_REF_STOP : CY_ILLEGAL;
      else       c = dsf ? CY_REF_KEEP : CY_REF_CLEAR;
    end else if (!trg_n) begin
      if (we_n)      c = dsf ? CY_XF_SPLIT : CY_XF_RD;
      else if (!dsf) c = CY_XF_WM;
      else           c = dsf_cas ? CY_XF_FLASH : CY_XF_SPLIT_W;
    end else if (!we_n) begin
      if (dsf) c = CY_ILLEGAL;
      else     c = dsf_cas ? CY_BLOCK_M : CY_WRITE_M;
    end else if (dsf) begin
      c = dsf_cas ? CY_LOAD_COLOR : CY_LOAD_MASK;
    end else if (!we_fell) begin
      c = CY_READ;
    end else begin
      c = dsf_cas ? CY_BLOCK : CY_WRITE;
    end
    return c;
  endfunction

  function automatic logic uses_bit_mask(input cyc_e c);
    return (c == CY_WRITE_M) || (c == CY_BLOCK_M) || (c == CY_XF_WM) ||
           (c == CY_XF_SPLIT_W) || (c == CY_XF_FLASH);
  endfunction

  function automatic logic is_block(input cyc_e c);
    return (c == CY_BLOCK) || (c == CY_BLOCK_M);
  endfunction

endpackage

// File: rtl/vram_strobe_edges.sv
module vram_strobe_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic casl_n,
  input  logic casu_n,
  input  logic we_n,
  output logic cas_low,
  output logic ras_fall,
  output logic ras_rise,
  output logic cas_fall,
  output logic we_fall
);

  localparam int NS = 3;

  logic [NS-1:0] lvl, prev_q, prev_d;

  assign cas_low = ~(casl_n & casu_n);
  assign lvl     = {we_n, ~cas_low, ras_n};
  assign prev_d  = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= prev_d;
  end

  assign ras_fall = prev_q[0] & ~lvl[0];
  assign ras_rise = ~prev_q[0] & lvl[0];
  assign cas_fall = prev_q[1] & ~lvl[1];
  assign we_fall  = prev_q[2] & ~lvl[2];

endmodule

// File: rtl/vram_cycle_track.sv
module vram_cycle_track
  import vram_dec_pkg::*;
#(
  parameter int AW      = 9,
  parameter int DW      = 16,
  parameter int BLK_LSB = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_fall,
  input  logic             ras_rise,
  input  logic             cas_fall,
  input  logic             we_fall,
  input  logic             cas_low,
  input  logic             trg_n,
  input  logic             we_n,
  input  logic             dsf,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    dq,
  input  logic             persist,
  input  logic [DW-1:0]    mask_reg,
  output logic             done,
  output cyc_e             fin_code,
  output logic [DW-1:0]    fin_data,
  output logic [AW-1:0]    fin_row,
  output logic             cyc_valid,
  output logic [3:0]       cyc_code,
  output logic [AW-1:0]    row_addr,
  output logic [AW-1:0]    col_addr,
  output logic [AW-BLK_LSB-1:0] blk_addr,
  output logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    wr_mask,
  output logic [DW-1:0]    col_mask
);

  typedef struct packed {
    logic          in_cyc;
    logic          cbr;
    logic          trg_n;
    logic          we_n;
    logic          dsf;
    logic          dsf_cas;
    logic          cas_seen;
    logic          data_got;
    logic          we_fell;
    logic [AW-1:0] row;
    logic [AW-1:0] col;
    logic [DW-1:0] mbus;
    logic [DW-1:0] data;
  } trk_t;

  trk_t cur_q, nxt_d;

  always_comb begin
    nxt_d = cur_q;
    if (ras_fall) begin
      nxt_d.in_cyc   = 1'b1;
      nxt_d.cbr      = cas_low;
      nxt_d.trg_n    = trg_n;
      nxt_d.we_n     = we_n;
      nxt_d.dsf      = dsf;
      nxt_d.row      = addr;
      nxt_d.mbus     = dq;
      nxt_d.dsf_cas  = 1'b0;
      nxt_d.cas_seen = 1'b0;
      nxt_d.data_got = 1'b0;
      nxt_d.we_fell  = 1'b0;
      nxt_d.col      = '0;
      nxt_d.data     = '0;
    end else if (cur_q.in_cyc) begin
      if (cas_fall && !cur_q.cas_seen) begin
        nxt_d.cas_seen = 1'b1;
        nxt_d.col      = addr;
        nxt_d.dsf_cas  = dsf;
        if (!we_n) begin
          nxt_d.data     = dq;
          nxt_d.data_got = 1'b1;
        end
      end
      if (we_fall) begin
        nxt_d.we_fell = 1'b1;
        if (cur_q.cas_seen && !cur_q.data_got) begin
          nxt_d.data     = dq;
          nxt_d.data_got = 1'b1;
        end
      end
      if (ras_rise) nxt_d.in_cyc = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt_d;
  end

  assign done     = cur_q.in_cyc & ras_rise;
  assign fin_code = classify(cur_q.cbr, cur_q.trg_n, cur_q.we_n, cur_q.dsf,
                             nxt_d.dsf_cas, nxt_d.we_fell);
  assign fin_data = nxt_d.data;
  assign fin_row  = cur_q.row;

  logic [DW-1:0] mask_d, cmask_d;
  always_comb begin
    mask_d  = '1;
    cmask_d = '1;
    if (uses_bit_mask(fin_code)) mask_d = persist ? mask_reg : cur_q.mbus;
    if (is_block(fin_code))      cmask_d = fin_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_valid <= 1'b0;
    else        cyc_valid <= done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_code <= '0;
      row_addr <= '0;
      col_addr <= '0;
      blk_addr <= '0;
      wr_data  <= '0;
      wr_mask  <= '1;
      col_mask <= '1;
    end else if (done) begin
      cyc_code <= fin_code;
      row_addr <= cur_q.row;
      col_addr <= nxt_d.col;
      blk_addr <= nxt_d.col[AW-1:BLK_LSB];
      wr_data  <= fin_data;
      wr_mask  <= mask_d;
      col_mask <= cmask_d;
    end
  end

endmodule

// File: rtl/vram_mode_regs.sv
module vram_mode_regs
  import vram_dec_pkg::*;
#(
  parameter int AW       = 9,
  parameter int DW       = 16,
  parameter int STOP_LSB = 4,
  parameter int STOP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  cyc_e              fin_code,
  input  logic [DW-1:0]     fin_data,
  input  logic [AW-1:0]     fin_row,
  output logic              persist_on,
  output logic              stop_on,
  output logic [STOP_W-1:0] stop_code,
  output logic [DW-1:0]     mask_reg,
  output logic [DW-1:0]     color_reg
);

  logic              pers_d, stop_d;
  logic [STOP_W-1:0] code_d;
  logic [DW-1:0]     mask_d, color_d;

  always_comb begin
    pers_d  = persist_on;
    stop_d  = stop_on;
    code_d  = stop_code;
    mask_d  = mask_reg;
    color_d = color_reg;
    if (done) begin
      unique case (fin_code)
        CY_LOAD_MASK: begin
          mask_d = fin_data;
          pers_d = 1'b1;
        end
        CY_LOAD_COLOR: color_d = fin_data;
        CY_REF_CLEAR: begin
          pers_d = 1'b0;
          stop_d = 1'b0;
        end
        CY_REF_STOP: begin
          stop_d = 1'b1;
          code_d = fin_row[STOP_LSB +: STOP_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      persist_on <= 1'b0;
      stop_on    <= 1'b0;
      stop_code  <= '0;
      mask_reg   <= '1;
      color_reg  <= '0;
    end else begin
      persist_on <= pers_d;
      stop_on    <= stop_d;
      stop_code  <= code_d;
      mask_reg   <= mask_d;
      color_reg  <= color_d;
    end
  end

endmodule

// File: rtl/vram_cycle_decoder.sv
module vram_cycle_decoder
  import vram_dec_pkg::*;
#(
  parameter int AW       = 9,
  parameter int DW       = 16,
  parameter int BLK_LSB  = 3,
  parameter int STOP_LSB = 4,
  parameter int STOP_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ras_n,
  input  logic                  casl_n,
  input  logic                  casu_n,
  input  logic                  trg_n,
  input  logic                  we_n,
  input  logic                  dsf,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         dq,
  output logic                  cyc_valid,
  output logic [3:0]            cyc_code,
  output logic [AW-1:0]         row_addr,
  output logic [AW-1:0]         col_addr,
  output logic [AW-BLK_LSB-1:0] blk_addr,
  output logic [DW-1:0]         wr_data,
  output logic [DW-1:0]         wr_mask,
  output logic [DW-1:0]         col_mask,
  output logic                  persist_on,
  output logic                  stop_on,
  output logic [STOP_W-1:0]     stop_code,
  output logic [DW-1:0]         mask_reg,
  output logic [DW-1:0]         color_reg
);

  logic          cas_low, ras_fall, ras_rise, cas_fall, we_fall;
  logic          done;
  cyc_e          fin_code;
  logic [DW-1:0] fin_data;
  logic [AW-1:0] fin_row;

  vram_strobe_edges u_edges (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n),
    .casu_n(casu_n), .we_n(we_n), .cas_low(cas_low), .ras_fall(ras_fall),
    .ras_rise(ras_rise), .cas_fall(cas_fall), .we_fall(we_fall)
  );

  vram_cycle_track #(.AW(AW), .DW(DW), .BLK_LSB(BLK_LSB)) u_track (
    .clk(clk), .rst_n(rst_n), .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .we_fall(we_fall), .cas_low(cas_low),
    .trg_n(trg_n), .we_n(we_n), .dsf(dsf), .addr(addr), .dq(dq),
    .persist(persist_on), .mask_reg(mask_reg), .done(done),
    .fin_code(fin_code), .fin_data(fin_data), .fin_row(fin_row),
    .cyc_valid(cyc_valid), .cyc_code(cyc_code), .row_addr(row_addr),
    .col_addr(col_addr), .blk_addr(blk_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .col_mask(col_mask)
  );

  vram_mode_regs #(.AW(AW), .DW(DW), .STOP_LSB(STOP_LSB), .STOP_W(STOP_W)) u_modes (
    .clk(clk), .rst_n(rst_n), .done(done), .fin_code(fin_code),
    .fin_data(fin_data), .fin_row(fin_row), .persist_on(persist_on),
    .stop_on(stop_on), .stop_code(stop_code), .mask_reg(mask_reg),
    .color_reg(color_reg)
  );

endmodule

// File: rtl/vram_cycle_decoder_chk.sv
module vram_cycle_decoder_chk #(
  parameter int AW       = 9,
  parameter int DW       = 16,
  parameter int BLK_LSB  = 3,
  parameter int STOP_W   = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ras_n,
  input logic                  casl_n,
  input logic                  casu_n,
  input logic                  trg_n,
  input logic                  we_n,
  input logic                  dsf,
  input logic [AW-1:0]         addr,
  input logic [DW-1:0]         dq,
  input logic                  cyc_valid,
  input logic [3:0]            cyc_code,
  input logic [AW-1:0]         row_addr,
  input logic [AW-1:0]         col_addr,
  input logic [AW-BLK_LSB-1:0] blk_addr,
  input logic [DW-1:0]         wr_data,
  input logic [DW-1:0]         wr_mask,
  input logic [DW-1:0]         col_mask,
  input logic                  persist_on,
  input logic                  stop_on,
  input logic [STOP_W-1:0]     stop_code,
  input logic [DW-1:0]         mask_reg,
  input logic [DW-1:0]         color_reg
);

  logic masked_code;
  assign masked_code = (cyc_code == 4'd2) || (cyc_code == 4'd4) ||
                       (cyc_code == 4'd9) || (cyc_code == 4'd10) ||
                       (cyc_code == 4'd11);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);

  assert_mask_load_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_code == 4'd5) |-> (persist_on && mask_reg == wr_data));

  assert_persist_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(persist_on) |-> (cyc_valid && cyc_code == 4'd5));

  assert_persist_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(persist_on) |-> (cyc_valid && cyc_code == 4'd13));

  assert_stop_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_on) |-> (cyc_valid && cyc_code == 4'd13));

  assert_stop_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_valid && cyc_code == 4'd14) |-> $stable(stop_code));

  assert_persist_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && masked_code && persist_on) |-> (wr_mask == mask_reg));

  assert_block_cmask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_code != 4'd3 && cyc_code != 4'd4) |-> (col_mask == '1));

  assert_illegal_noop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_code == 4'd15) |->
      ($stable(mask_reg) && $stable(color_reg) && $stable(stop_code) &&
       $stable(stop_on) && $stable(persist_on)));

endmodule

bind vram_cycle_decoder vram_cycle_decoder_chk u_chk (.*);

// File: tb/tb_vram_cycle_decoder.sv
module tb_vram_cycle_decoder;

  logic        clk, rst_n;
  logic        ras_n, casl_n, casu_n, trg_n, we_n, dsf;
  logic [8:0]  addr;
  logic [15:0] dq;
  logic        cyc_valid;
  logic [3:0]  cyc_code;
  logic [8:0]  row_addr, col_addr;
  logic [5:0]  blk_addr;
  logic [15:0] wr_data, wr_mask, col_mask;
  logic        persist_on, stop_on;
  logic [3:0]  stop_code;
  logic [15:0] mask_reg, color_reg;

  int checks = 0;
  int errors = 0;

  vram_cycle_decoder dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .casu_n(casu_n),
    .trg_n(trg_n), .we_n(we_n), .dsf(dsf), .addr(addr), .dq(dq),
    .cyc_valid(cyc_valid), .cyc_code(cyc_code), .row_addr(row_addr),
    .col_addr(col_addr), .blk_addr(blk_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .col_mask(col_mask), .persist_on(persist_on),
    .stop_on(stop_on), .stop_code(stop_code), .mask_reg(mask_reg),
    .color_reg(color_reg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One access cycle; a report is sampled in the clock after the row rise.
  // late_we: 1 = write falls after the column fall (data presented then).
  task automatic run_cycle(input logic cbr, input logic trg, input logic we_r,
                           input logic dsf_r, input logic [8:0] row,
                           input logic [15:0] dq_r, input logic dsf_c,
                           input logic [8:0] col, input logic late_we,
                           input logic [15:0] data, input int cas_sel);
    @(negedge clk);
    trg_n = trg; we_n = we_r; dsf = dsf_r; addr = row; dq = dq_r;
    if (cbr) begin casl_n = 1'b0; casu_n = 1'b0; end
    @(negedge clk);
    ras_n = 1'b0;
    @(negedge clk);
    trg_n = 1'b1;
    if (!cbr) begin
      addr = col; dsf = dsf_c; dq = late_we ? 16'hDEAD : data;
      casl_n = (cas_sel == 2); casu_n = (cas_sel == 1);
    end
    @(negedge clk);
    addr = 9'h000;
    if (late_we) begin dq = data; we_n = 1'b0; end
    else dq = 16'hBEEF;
    @(negedge clk);
    dq = 16'h1234;
    @(negedge clk);
    ras_n = 1'b1;
    @(negedge clk);
    chk("R2", "valid pulse", cyc_valid, 1'b1);
    casl_n = 1'b1; casu_n = 1'b1; we_n = 1'b1; dsf = 1'b0;
    @(negedge clk);
    chk("R2", "pulse one clock", cyc_valid, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1", "valid", cyc_valid, 1'b0);
    chk("R1", "persist", persist_on, 1'b0);
    chk("R1", "stop", stop_on, 1'b0);
    chk("R1", "mask_reg", mask_reg, 16'hFFFF);
    chk("R1", "color", color_reg, 16'h0000);
    chk("R1", "stop_code", stop_code, 4'h0);
  endtask

  task automatic t_plain_write;
    run_cycle(0, 1, 1, 0, 9'h0A5, 16'h5555, 0, 9'h13C, 1, 16'hC0DE, 1);
    chk("R2", "code write", cyc_code, 4'd1);
    chk("R3", "col lower strobe", col_addr, 9'h13C);
    chk("R3", "row", row_addr, 9'h0A5);
    chk("R4", "late data", wr_data, 16'hC0DE);
    chk("R9", "plain mask", wr_mask, 16'hFFFF);
    chk("R5", "plain colmask", col_mask, 16'hFFFF);
  endtask

  task automatic t_read;
    run_cycle(0, 1, 1, 0, 9'h001, 16'h0, 0, 9'h002, 0, 16'h7777, 0);
    chk("R2", "code read", cyc_code, 4'd0);
  endtask

  task automatic t_masked_write;
    run_cycle(0, 1, 0, 0, 9'h044, 16'h00FF, 0, 9'h055, 0, 16'hABCD, 0);
    chk("R2", "code masked write", cyc_code, 4'd2);
    chk("R4", "early data", wr_data, 16'hABCD);
    chk("R9", "bus mask", wr_mask, 16'h00FF);
  endtask

  task automatic t_loads;
    run_cycle(0, 1, 1, 1, 9'h0, 16'h0, 1, 9'h0, 1, 16'hA5A5, 0);
    chk("R2", "code color", cyc_code, 4'd6);
    chk("R6", "color reg", color_reg, 16'hA5A5);
    chk("R6", "no persist", persist_on, 1'b0);
    run_cycle(0, 1, 1, 1, 9'h0, 16'h0, 0, 9'h0, 1, 16'h0F0F, 0);
    chk("R2", "code mask load", cyc_code, 4'd5);
    chk("R6", "mask reg", mask_reg, 16'h0F0F);
    chk("R6", "persist on", persist_on, 1'b1);
  endtask

  task automatic t_persist_writes;
    run_cycle(0, 1, 0, 0, 9'h010, 16'hFFFF, 0, 9'h020, 0, 16'h1111, 0);
    chk("R9", "persist mask write", wr_mask, 16'h0F0F);
    run_cycle(0, 1, 0, 0, 9'h011, 16'hFFFF, 1, 9'h1F8, 0, 16'h8421, 2);
    chk("R2", "code masked block", cyc_code, 4'd4);
    chk("R3", "block addr upper strobe", blk_addr, 6'h3F);
    chk("R5", "column mask", col_mask, 16'h8421);
    chk("R9", "block mask", wr_mask, 16'h0F0F);
  endtask

  task automatic t_transfers;
    run_cycle(0, 0, 1, 0, 9'h030, 16'h0, 0, 9'h040, 0, 16'h0, 0);
    chk("R2", "code read xfer", cyc_code, 4'd7);
    run_cycle(0, 0, 1, 1, 9'h030, 16'h0, 0, 9'h040, 0, 16'h0, 0);
    chk("R2", "code split xfer", cyc_code, 4'd8);
    run_cycle(0, 0, 0, 0, 9'h030, 16'hFFFF, 0, 9'h040, 0, 16'h0, 0);
    chk("R2", "code masked xfer", cyc_code, 4'd9);
    chk("R9", "xfer persist mask", wr_mask, 16'h0F0F);
    run_cycle(0, 0, 0, 1, 9'h030, 16'hFFFF, 0, 9'h040, 0, 16'h0, 0);
    chk("R2", "code split masked xfer", cyc_code, 4'd10);
    run_cycle(0, 0, 0, 1, 9'h030, 16'hFFFF, 1, 9'h040, 0, 16'h0, 0);
    chk("R2", "code flash", cyc_code, 4'd11);
    chk("R9", "flash mask", wr_mask, 16'h0F0F);
  endtask

  task automatic t_stop_and_refresh;
    run_cycle(1, 1, 0, 1, 9'b1_1010_0110, 16'h0, 0, 9'h0, 0, 16'h0, 0);
    chk("R2", "code stop set", cyc_code, 4'd14);
    chk("R8", "stop code", stop_code, 4'hA);
    chk("R8", "stop on", stop_on, 1'b1);
    run_cycle(1, 1, 1, 1, 9'h0F0, 16'h0, 0, 9'h0, 0, 16'h0, 0);
    chk("R2", "code keep refresh", cyc_code, 4'd12);
    chk("R7", "keep persist", persist_on, 1'b1);
    chk("R7", "keep stop", stop_on, 1'b1);
  endtask

  task automatic t_illegal;
    run_cycle(0, 1, 0, 1, 9'h0, 16'h0, 1, 9'h0, 0, 16'h9999, 0);
    chk("R2", "code illegal", cyc_code, 4'd15);
    chk("R10", "mask kept", mask_reg, 16'h0F0F);
    chk("R10", "color kept", color_reg, 16'hA5A5);
    run_cycle(1, 1, 0, 0, 9'h050, 16'h0, 0, 9'h0, 0, 16'h0, 0);
    chk("R2", "code refresh illegal", cyc_code, 4'd15);
    chk("R10", "stop code kept", stop_code, 4'hA);
    chk("R10", "stop kept", stop_on, 1'b1);
    chk("R10", "persist kept", persist_on, 1'b1);
  endtask

  task automatic t_clear;
    run_cycle(1, 1, 1, 0, 9'h0, 16'h0, 0, 9'h0, 0, 16'h0, 0);
    chk("R2", "code clear refresh", cyc_code, 4'd13);
    chk("R7", "persist cleared", persist_on, 1'b0);
    chk("R7", "stop cleared", stop_on, 1'b0);
    run_cycle(0, 1, 0, 0, 9'h012, 16'h3C3C, 0, 9'h021, 0, 16'h2222, 0);
    chk("R9", "bus mask after clear", wr_mask, 16'h3C3C);
  endtask

  initial begin
    rst_n = 1'b0; ras_n = 1'b1; casl_n = 1'b1; casu_n = 1'b1;
    trg_n = 1'b1; we_n = 1'b1; dsf = 1'b0; addr = '0; dq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_write();
    t_read();
    t_masked_write();
    t_loads();
    t_persist_writes();
    t_transfers();
    t_stop_and_refresh();
    t_illegal();
    t_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule